// File: doc/BRIEF.md
# Guarded Clock Source Control Register

This block is a single software-visible control register that selects the core clock source. It holds a main PLL run bit and a 2-bit source select code, and it drives a registered selection line into a downstream clock multiplexer. Because a bad setting could stall or glitch the clock tree, the block judges every write before it stores it. A change to the run bit is refused while the PLL is the live source. A move to the PLL is refused unless the PLL was already running. Some direct jumps between select codes are always refused.

A refused field keeps its old value, and a sticky violation flag records the refusal. Software reads back both fields and the flag at any time, and clears the flag by writing 1 to it. The PLL itself, its lock detection, the oscillator and the multiplexer are outside this block.

Top module: `clksrc_guard`

## Requirements
- R1: After a synchronous reset, the run bit is 0, the select code is 00, the violation flag is 0 and `pll_sel_o` is 0.
- R2: `rd_data` shows the select code on bits [1:0], the run bit on bit 4 and the violation flag on bit 8, with every other bit 0, at all times.
- R3: A write with `wr_be[0]` set stores a new select code when the step is allowed: 00 to 01, 00 to 10, 01 to 00, 01 to 11, 10 to 00, or 11 to 01.
- R4: Any other change of the select code is refused (for example 00 to 11, 01 to 10, 10 to 01, 11 to 00, 10 to 11, 11 to 10), and the stored code keeps its value.
- R5: A write that would move the select code to 10 (PLL) is refused when the run bit was 0 before that write.
- R6: While the stored select code is 10, a write that tries to change the run bit leaves the run bit unchanged.
- R7: Writing back the value already stored in a field is always accepted and never sets the violation flag.
- R8: Each refused field sets the violation flag, which then stays set. A write with `wr_be[1]` set and bit 8 at 1 clears the flag, except when the same write is itself refused, in which case the flag stays set.
- R9: A write with `wr_be[0]` clear leaves the run bit and the select code unchanged, whatever byte 0 of `wr_data` holds.
- R10: `pll_sel_o` is 1 exactly when the stored select code was 10 one cycle earlier. It changes one clock after the register does, and codes 00, 01 and 11 drive 0.
- R11: When one write changes both fields, both are judged against the contents before the write. Setting the run bit and selecting 10 in the same write stores the run bit and refuses the select code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Byte enables; byte 0 holds the fields, byte 1 the flag clear |
| rd_data | output | DATA_W | Read data: fields and violation flag |
| viol_o | output | 1 | Sticky violation flag |
| pll_sel_o | output | 1 | Registered source select to the clock multiplexer, 1 selects the PLL |

## Verification
The checker watches, on every cycle, that refused select steps and PLL selection without a running PLL leave the code unchanged. It also checks that the run bit is frozen while the PLL is selected, that writes without byte 0 touch nothing, that the flag stays set until a clear, that the read layout keeps its unused bits at zero, and that the multiplexer line lags the stored code by one cycle. The bench's scenarios are what show that the allowed steps actually take effect. The bench walks every current/next select pair under both run-bit states and compares the result with its own table. Only those scenarios can show that a combined write judges both fields against the old contents, and that a refusal in the same write wins over a flag clear.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    typedef enum logic [1:0] {
        SRC_OSC_DIV_A = 2'b00,
        SRC_OSC_DIV_B = 2'b01,
        SRC_PLL       = 2'b10,
        SRC_RESERVED  = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic     pll_on;
        src_sel_e sel;
    } ctrl_t;

    localparam int SEL_LSB  = 0;
    localparam int RUN_BIT  = 4;
    localparam int FLAG_BIT = 8;

    // Allowed direct moves of the select code; staying put is always fine.
    function automatic logic step_ok(input src_sel_e cur, input src_sel_e nxt);
        logic ok;
        if (cur == nxt) begin
            ok = 1'b1;
        end else begin
            case (cur)
                SRC_OSC_DIV_A: ok = (nxt == SRC_OSC_DIV_B) || (nxt == SRC_PLL);
                SRC_OSC_DIV_B: ok = (nxt == SRC_OSC_DIV_A) || (nxt == SRC_RESERVED);
                SRC_PLL:       ok = (nxt == SRC_OSC_DIV_A);
                SRC_RESERVED:  ok = (nxt == SRC_OSC_DIV_B);
                default:       ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

endpackage

// File: rtl/clksrc_judge.sv
module clksrc_judge
    import clksrc_pkg::*;
(
    input  ctrl_t cur,
    input  ctrl_t req,
    input  logic  fld_wr,
    output ctrl_t nxt,
    output logic  en_rej,
    output logic  sel_rej
);
    logic en_chg;
    logic sel_chg;

    always_comb begin
        en_chg  = (req.pll_on != cur.pll_on);
        sel_chg = (req.sel != cur.sel);

        // Both fields are judged against the contents before the write.
        en_rej  = fld_wr && en_chg && (cur.sel == SRC_PLL);
        sel_rej = fld_wr && sel_chg &&
                  (!step_ok(cur.sel, req.sel) ||
                   ((req.sel == SRC_PLL) && !cur.pll_on));

        nxt = cur;
        if (fld_wr && !en_rej)  nxt.pll_on = req.pll_on;
        if (fld_wr && !sel_rej) nxt.sel    = req.sel;
    end
endmodule

// File: rtl/clksrc_regs.sv
module clksrc_regs
    import clksrc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t nxt,
    input  logic  any_rej,
    input  logic  flag_clr,
    output ctrl_t cur,
    output logic  flag,
    output logic  pll_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '{pll_on: 1'b0, sel: SRC_OSC_DIV_A};
            flag    <= 1'b0;
            pll_sel <= 1'b0;
        end else begin
            cur <= nxt;
            if (any_rej)       flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
            // Reserved code falls to the divided oscillator.
            pll_sel <= (cur.sel == SRC_PLL);
        end
    end
endmodule

// File: rtl/clksrc_guard.sv
module clksrc_guard
    import clksrc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    output logic [DATA_W-1:0]   rd_data,
    output logic                viol_o,
    output logic                pll_sel_o
);
    localparam int BE_W = DATA_W / 8;

    ctrl_t cur_q;
    ctrl_t req;
    ctrl_t nxt;
    logic  en_rej;
    logic  sel_rej;
    logic  fld_wr;
    logic  flag_clr;
    logic  flag_q;
    logic  unused_bits;

    assign fld_wr   = wr_en && wr_be[0];
    assign flag_clr = wr_en && wr_be[1] && wr_data[FLAG_BIT];
    assign req.pll_on = wr_data[RUN_BIT];
    assign req.sel    = src_sel_e'(wr_data[SEL_LSB +: 2]);
    assign unused_bits = ^{wr_data, wr_be, BE_W[0]};

    clksrc_judge u_judge (
        .cur     (cur_q),
        .req     (req),
        .fld_wr  (fld_wr),
        .nxt     (nxt),
        .en_rej  (en_rej),
        .sel_rej (sel_rej)
    );

    clksrc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .nxt      (nxt),
        .any_rej  (en_rej || sel_rej),
        .flag_clr (flag_clr),
        .cur      (cur_q),
        .flag     (flag_q),
        .pll_sel  (pll_sel_o)
    );

    always_comb begin
        rd_data                  = '0;
        rd_data[SEL_LSB +: 2]    = cur_q.sel;
        rd_data[RUN_BIT]         = cur_q.pll_on;
        rd_data[FLAG_BIT]        = flag_q;
    end

    assign viol_o = flag_q;
endmodule

// File: rtl/clksrc_guard_chk.sv
module clksrc_guard_chk
    import clksrc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W/8-1:0] wr_be,
    input logic [DATA_W-1:0]   rd_data,
    input logic                viol_o,
    input logic                pll_sel_o
);
    logic rst_q;
    logic armed;
    logic [1:0] s_cur;
    logic [1:0] s_req;
    logic e_cur;
    logic e_req;
    logic [DATA_W-1:0] used_mask;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        armed <= !rst;
    end

    assign s_cur = rd_data[SEL_LSB +: 2];
    assign s_req = wr_data[SEL_LSB +: 2];
    assign e_cur = rd_data[RUN_BIT];
    assign e_req = wr_data[RUN_BIT];

    always_comb begin
        used_mask = '0;
        used_mask[SEL_LSB +: 2] = 2'b11;
        used_mask[RUN_BIT]      = 1'b1;
        used_mask[FLAG_BIT]     = 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (rd_data == '0) && !pll_sel_o && !viol_o);

    a_r2_layout: assert property (@(posedge clk) disable iff (rst || !armed)
        ((rd_data & ~used_mask) == '0) && (rd_data[FLAG_BIT] == viol_o));

    a_r4_bad_step_kept: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && wr_be[0] && !step_ok(src_sel_e'(s_cur), src_sel_e'(s_req)))
        |=> (s_cur == $past(s_cur)));

    a_r5_pll_needs_run: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && wr_be[0] && !e_cur && (s_cur != 2'b10) && (s_req == 2'b10))
        |=> (s_cur != 2'b10));

    a_r6_run_frozen: assert property (@(posedge clk) disable iff (rst || !armed)
        (s_cur == 2'b10) |=> (e_cur == $past(e_cur)));

    a_r8_run_refusal_flags: assert property (@(posedge clk) disable iff (rst || !armed)
        (wr_en && wr_be[0] && (s_cur == 2'b10) && (e_req != e_cur)) |=> viol_o);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst || !armed)
        (viol_o && !(wr_en && wr_be[1] && wr_data[FLAG_BIT])) |=> viol_o);

    a_r9_no_byte0: assert property (@(posedge clk) disable iff (rst || !armed)
        !(wr_en && wr_be[0]) |=> ($stable(s_cur) && $stable(e_cur)));

    a_r10_mux_lag: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |=> (pll_sel_o == ($past(s_cur) == 2'b10)));

endmodule

bind clksrc_guard clksrc_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .rd_data   (rd_data),
    .viol_o    (viol_o),
    .pll_sel_o (pll_sel_o)
);

// File: tb/sim_clksrc_guard.sv
`timescale 1ns/1ps
module sim_clksrc_guard;
    localparam int DW = 16;
    // Allowed select steps, index cur*4+nxt.
    localparam bit ALLOW [16] = '{1,1,1,0, 1,1,0,1, 1,0,1,0, 0,1,0,1};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_be = '0;
    logic [DW-1:0] rd_data;
    logic          viol_o;
    logic          pll_sel_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clksrc_guard #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_be(wr_be), .rd_data(rd_data), .viol_o(viol_o), .pll_sel_o(pll_sel_o)
    );

    function automatic logic [DW-1:0] img(input bit f, input bit e, input logic [1:0] s);
        return (DW'(f) << 8) | (DW'(e) << 4) | DW'(s);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [DW-1:0] d, input logic [1:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = '0;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 pll_sel", pll_sel_o, 0);
        chk("R1 viol", viol_o, 0);

        // Table walk over run bit, current and requested select codes.
        for (int en_t = 0; en_t < 2; en_t++) begin
            for (int cur = 0; cur < 4; cur++) begin
                for (int nxt = 0; nxt < 4; nxt++) begin
                    bit ok;
                    string tag;
                    if (en_t == 0 && cur == 2) continue;
                    do_reset();
                    wr(img(0, 1, 2'd0), 2'b01);
                    if (cur == 1) wr(img(0, 1, 2'd1), 2'b01);
                    if (cur == 2) wr(img(0, 1, 2'd2), 2'b01);
                    if (cur == 3) begin
                        wr(img(0, 1, 2'd1), 2'b01);
                        wr(img(0, 1, 2'd3), 2'b01);
                    end
                    if (en_t == 0) wr(img(0, 0, 2'(cur)), 2'b01);
                    chk("R3 setup", rd_data, img(0, en_t[0], 2'(cur)));
                    ok = ALLOW[cur*4+nxt] && !(nxt == 2 && cur != 2 && en_t == 0);
                    if (cur == nxt)                          tag = "R7 same";
                    else if (nxt == 2 && en_t == 0)          tag = "R5 pll_off";
                    else if (ok)                             tag = "R3 allowed";
                    else                                     tag = "R4 forbidden";
                    wr(img(0, en_t[0], 2'(nxt)), 2'b01);
                    chk(tag, rd_data, img(!ok, en_t[0], ok ? 2'(nxt) : 2'(cur)));
                end
            end
        end

        // R10 registered mux line, one cycle after the register.
        do_reset();
        wr(img(0, 1, 2'd0), 2'b01);
        wr(img(0, 1, 2'd2), 2'b01);
        chk("R10 sel stored", rd_data, img(0, 1, 2'd2));
        chk("R10 lag", pll_sel_o, 0);
        @(negedge clk);
        chk("R10 pll", pll_sel_o, 1);

        // R6 run bit frozen while PLL selected.
        wr(img(0, 0, 2'd2), 2'b01);
        chk("R6 run kept", rd_data, img(1, 1, 2'd2));
        // R8 clear by writing 1 to the flag with byte 1.
        wr(img(1, 0, 2'd0), 2'b10);
        chk("R8 cleared", rd_data, img(0, 1, 2'd2));
        // R8 refusal in the same write wins over the clear.
        wr(img(1, 1, 2'd1), 2'b11);
        chk("R8 set wins", rd_data, img(1, 1, 2'd2));
        wr(img(1, 0, 2'd0), 2'b10);
        // R9 byte 0 disabled: forbidden data has no effect.
        wr(img(0, 0, 2'd1), 2'b00);
        chk("R9 no byte0", rd_data, img(0, 1, 2'd2));
        wr(img(0, 1, 2'd0), 2'b01);
        chk("R3 leave pll", rd_data, img(0, 1, 2'd0));
        @(negedge clk);
        chk("R10 back to osc", pll_sel_o, 0);

        // R10 reserved code drives the divided oscillator.
        wr(img(0, 1, 2'd1), 2'b01);
        wr(img(0, 1, 2'd3), 2'b01);
        @(negedge clk);
        chk("R10 reserved", pll_sel_o, 0);
        chk("R2 readback", rd_data, img(0, 1, 2'd3));

        // R11 combined write judged against old contents.
        do_reset();
        wr(img(0, 1, 2'd2), 2'b01);
        chk("R11 combined", rd_data, img(1, 1, 2'd0));
        chk("R8 viol port", viol_o, 1);

        // R7 repeat write of stored value keeps the flag clear.
        do_reset();
        wr(img(0, 0, 2'd0), 2'b11);
        chk("R7 repeat", rd_data, img(0, 0, 2'd0));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule